// File: doc/BRIEF.md
# Sticky Interrupt Status Gate

This block gathers event indications from a serial flash controller's transmit FIFO, receive FIFO and descriptor engine into one sticky status register, and drives a single interrupt line from it. The FIFO conditions (empty, full, threshold crossed) come from live fill levels. They are compared inside the block against two programmable threshold fields. The descriptor-done, packet-complete and DMA-error indications arrive as one-cycle pulses.

Two masks gate the path to the line. The event-enable mask decides which events may latch into the status register and which latched bits count as pending. The line-enable mask decides which pending bits may raise the interrupt line. Software can retire a handled condition in two ways: by clearing its event-enable bit, which stops it being reported while the status bit stays set, or by a write-one-to-clear into the status register. A soft-reset input wipes the status and the event-enable mask.

The line is driven by a two-state machine, `LINE_QUIET` and `LINE_RAISED`. It goes from quiet to raised when any bit is set in status, event-enable and line-enable at once, and back to quiet when no bit is. This registers the line one cycle behind the status.

Top module: `irq_status_gate`

## Requirements
- R1: All three 12-bit masks (status, event-enable, line-enable) use one layout: tx empty bit 0, tx full bit 1, tx threshold bit 2, rx empty bit 3, rx full bit 4, rx threshold bit 5, descriptor done bit 9, packet complete bit 10, DMA error bit 11. Bits 6 to 8 always read 0, even after a write of ones.
- R2: Each cycle, a FIFO condition sets its status bit at the next clock edge if its event-enable bit is set. The conditions are: empty when the level is 0, full when the level equals DEPTH (16 by default), tx threshold when the tx level is at or below the tx threshold, and rx threshold when the rx level is at or above the rx threshold. With the enable bit clear, the condition does not latch.
- R3: A one-cycle pulse on a descriptor-done, packet-complete or DMA-error input sets its status bit at the next edge only if its event-enable bit is set.
- R4: A set status bit stays set after its cause ends, until a clear write or a soft reset.
- R5: A write with cfg_sel = 2 clears every status bit whose cfg_wdata bit is 1. If an event for the same bit arrives in the same cycle, the bit stays set.
- R6: irq_o is registered. It is high in the cycle after some bit is set in status, event-enable and line-enable together, and low in the cycle after no such bit exists.
- R7: Clearing an event-enable bit (cfg_sel = 0) removes that bit's contribution to irq_o while its status bit stays set.
- R8: A pending bit whose line-enable bit (cfg_sel = 1) is clear does not raise irq_o.
- R9: A write with cfg_sel = 3 loads the tx threshold from cfg_wdata bits 12:8 and the rx threshold from bits 4:0. All other bits are ignored.
- R10: soft_rst clears status and event-enable at the next edge. It wins over events and writes in the same cycle and leaves line-enable and the thresholds unchanged.
- R11: After rst_n, status, both masks, both thresholds and irq_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of status and event-enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 event-enable, 1 line-enable, 2 status clear, 3 thresholds |
| cfg_wdata | input | 32 | Write data |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| desc_done_pulse | input | 1 | Descriptor finished, one-cycle pulse |
| pkt_done_pulse | input | 1 | Packet finished, one-cycle pulse |
| dma_err_pulse | input | 1 | DMA error, one-cycle pulse |
| status_o | output | 12 | Sticky status register |
| enable_o | output | 12 | Event-enable mask |
| sigen_o | output | 12 | Line-enable mask |
| tx_thr_o | output | 5 | Transmit threshold |
| rx_thr_o | output | 5 | Receive threshold |
| irq_o | output | 1 | Interrupt line |

## Verification
A clear write to the status register and a fresh event for the same bit can fall in one cycle. The bench provokes this by holding a DMA-error pulse high during the edge that applies a write-one-to-clear of bit 11. It judges that the bit stays set, and that a later clear with no pulse drops it. Soft reset is also raised together with a packet-complete pulse, and the bench checks that the reset wins.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
    localparam int STAT_W     = 12;
    localparam int THR_W      = 5;
    localparam int TX_THR_LSB = 8;
    localparam int RX_THR_LSB = 0;

    localparam int B_TX_EMPTY = 0;
    localparam int B_TX_FULL  = 1;
    localparam int B_TX_THR   = 2;
    localparam int B_RX_EMPTY = 3;
    localparam int B_RX_FULL  = 4;
    localparam int B_RX_THR   = 5;
    localparam int B_DESC     = 9;
    localparam int B_PKT      = 10;
    localparam int B_DMAERR   = 11;

    localparam logic [STAT_W-1:0] IMPL_MASK = 12'hE3F;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_SIGEN  = 2'd1,
        SEL_CLEAR  = 2'd2,
        SEL_THRESH = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;
endpackage

// File: rtl/irq_level_cond.sv
module irq_level_cond
    import irq_gate_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    output logic [5:0]       cond
);
    localparam int CW = (LVL_W > THR_W) ? LVL_W : THR_W;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic [CW-1:0] tx_l, rx_l, tx_t, rx_t;

    always_comb begin
        tx_l = CW'(tx_level);
        rx_l = CW'(rx_level);
        tx_t = CW'(tx_thr);
        rx_t = CW'(rx_thr);
        cond = '0;
        cond[B_TX_EMPTY] = (tx_level == '0);
        cond[B_TX_FULL]  = (tx_level == FULL_LVL);
        cond[B_TX_THR]   = (tx_l <= tx_t);
        cond[B_RX_EMPTY] = (rx_level == '0);
        cond[B_RX_FULL]  = (rx_level == FULL_LVL);
        cond[B_RX_THR]   = (rx_l >= rx_t);
    end
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank
    import irq_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    output logic [STAT_W-1:0] status
);
    logic unused_hole_bits;
    assign unused_hole_bits = ^((set_vec | clr_vec) & ~IMPL_MASK);

    for (genvar gi = 0; gi < STAT_W; gi++) begin : g_bit
        if (IMPL_MASK[gi]) begin : g_impl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    status[gi] <= 1'b0;
                else if (soft_rst)
                    status[gi] <= 1'b0;
                else
                    status[gi] <= set_vec[gi] | (status[gi] & ~clr_vec[gi]);
            end
        end else begin : g_hole
            assign status[gi] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic irq
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending)  state_d = LINE_RAISED;
            LINE_RAISED: if (!pending) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == LINE_RAISED);
    end
endmodule

// File: rtl/irq_status_gate.sv
module irq_status_gate
    import irq_gate_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              desc_done_pulse,
    input  logic              pkt_done_pulse,
    input  logic              dma_err_pulse,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] enable_o,
    output logic [STAT_W-1:0] sigen_o,
    output logic [THR_W-1:0]  tx_thr_o,
    output logic [THR_W-1:0]  rx_thr_o,
    output logic              irq_o
);
    logic [STAT_W-1:0] enable_q, sigen_q, event_vec, set_vec, clr_vec;
    logic [THR_W-1:0]  tx_thr_q, rx_thr_q;
    logic [5:0]        lvl_cond;
    logic              wr_en, wr_sig, wr_clr, wr_thr;
    logic              unused_wdata;

    assign unused_wdata = ^cfg_wdata[31:13];

    always_comb begin
        wr_en  = cfg_we && (cfg_sel == SEL_ENABLE);
        wr_sig = cfg_we && (cfg_sel == SEL_SIGEN);
        wr_clr = cfg_we && (cfg_sel == SEL_CLEAR);
        wr_thr = cfg_we && (cfg_sel == SEL_THRESH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            sigen_q  <= '0;
            tx_thr_q <= '0;
            rx_thr_q <= '0;
        end else begin
            if (soft_rst)
                enable_q <= '0;
            else if (wr_en)
                enable_q <= cfg_wdata[STAT_W-1:0] & IMPL_MASK;
            if (wr_sig)
                sigen_q <= cfg_wdata[STAT_W-1:0] & IMPL_MASK;
            if (wr_thr) begin
                tx_thr_q <= cfg_wdata[TX_THR_LSB +: THR_W];
                rx_thr_q <= cfg_wdata[RX_THR_LSB +: THR_W];
            end
        end
    end

    irq_level_cond #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_cond (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (tx_thr_q),
        .rx_thr   (rx_thr_q),
        .cond     (lvl_cond)
    );

    always_comb begin
        event_vec           = '0;
        event_vec[5:0]      = lvl_cond;
        event_vec[B_DESC]   = desc_done_pulse;
        event_vec[B_PKT]    = pkt_done_pulse;
        event_vec[B_DMAERR] = dma_err_pulse;
        set_vec = event_vec & enable_q;
        clr_vec = wr_clr ? cfg_wdata[STAT_W-1:0] : '0;
    end

    irq_sticky_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .status   (status_o)
    );

    irq_line_fsm u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|(status_o & enable_q & sigen_q)),
        .irq     (irq_o)
    );

    assign enable_o = enable_q;
    assign sigen_o  = sigen_q;
    assign tx_thr_o = tx_thr_q;
    assign rx_thr_o = rx_thr_q;
endmodule

// File: rtl/irq_status_gate_chk.sv
module irq_status_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        cfg_we,
    input logic [1:0]  cfg_sel,
    input logic        dma_err_pulse,
    input logic [11:0] status_o,
    input logic [11:0] enable_o,
    input logic [11:0] sigen_o,
    input logic        irq_o
);
    assert_holes_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[8:6] == 3'b0) && (enable_o[8:6] == 3'b0) && (sigen_o[8:6] == 3'b0));

    assert_err_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_err_pulse && enable_o[11] && !soft_rst) |=> status_o[11]);

    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status_o) & ~status_o)) |->
            ($past(soft_rst) || ($past(cfg_we) && ($past(cfg_sel) == 2'd2))));

    assert_line_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(status_o & enable_o & sigen_o)));

    assert_soft_wipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (status_o == 12'h0) && (enable_o == 12'h0));
endmodule

bind irq_status_gate irq_status_gate_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst      (soft_rst),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .dma_err_pulse (dma_err_pulse),
    .status_o      (status_o),
    .enable_o      (enable_o),
    .sigen_o       (sigen_o),
    .irq_o         (irq_o)
);

// File: tb/irq_status_gate_tb_top.sv
module irq_status_gate_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 5;
    localparam int NVEC = 6;
    // {tx_level, rx_level, tx_thr, rx_thr, expected status[5:0]}
    localparam logic [25:0] VECS [NVEC] = '{
        {5'd0,  5'd0,  5'd1,  5'd1, 6'b001101},
        {5'd16, 5'd16, 5'd1,  5'd1, 6'b110010},
        {5'd5,  5'd5,  5'd5,  5'd5, 6'b100100},
        {5'd6,  5'd4,  5'd5,  5'd5, 6'b000000},
        {5'd4,  5'd6,  5'd5,  5'd5, 6'b100100},
        {5'd16, 5'd0,  5'd31, 5'd0, 6'b101110}
    };

    logic clk = 0, rst_n = 0, soft_rst = 0, cfg_we = 0;
    logic [1:0] cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic [LW-1:0] tx_level = 0, rx_level = 0;
    logic desc_done_pulse = 0, pkt_done_pulse = 0, dma_err_pulse = 0;
    logic [11:0] status_o, enable_o, sigen_o;
    logic [4:0] tx_thr_o, rx_thr_o;
    logic irq_o;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_gate dut_i (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 0; cfg_wdata = 0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R11 reset state
        check("R11 status", 32'(status_o), 0);
        check("R11 enable", 32'(enable_o), 0);
        check("R11 sigen", 32'(sigen_o), 0);
        check("R11 thr", {22'b0, tx_thr_o, rx_thr_o}, 0);
        check("R11 irq", 32'(irq_o), 0);

        // R2 vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd0, 32'h0);
            tx_level = VECS[i][25:21];
            rx_level = VECS[i][20:16];
            wr(2'd3, {19'b0, VECS[i][15:11], 3'b0, VECS[i][10:6]});
            wr(2'd2, 32'hFFF);
            check("R2 disabled", 32'(status_o[5:0]), 0);
            wr(2'd0, 32'h03F);
            tick();
            check("R2 level cond", 32'(status_o[5:0]), 32'(VECS[i][5:0]));
        end
        wr(2'd0, 32'h0);
        wr(2'd2, 32'hFFF);
        tx_level = 5'd7; rx_level = 5'd7;

        // R1 holes
        wr(2'd0, 32'hFFFF_FFFF);
        check("R1 enable holes", 32'(enable_o), 32'hE3F);
        wr(2'd1, 32'hFFFF_FFFF);
        check("R1 sigen holes", 32'(sigen_o), 32'hE3F);
        wr(2'd1, 32'h0);

        // R3 pulse latch
        wr(2'd0, 32'h800);
        wr(2'd2, 32'hFFF);
        dma_err_pulse = 1; pkt_done_pulse = 1; tick();
        dma_err_pulse = 0; pkt_done_pulse = 0;
        check("R3 pulse latch / disabled pulse ignored", 32'(status_o), 32'h800);
        // R4 sticky
        repeat (3) tick();
        check("R4 sticky", 32'(status_o), 32'h800);

        // R8 no line enable
        check("R8 line gated", 32'(irq_o), 0);
        // R6 registered line
        wr(2'd1, 32'h800);
        check("R6 one cycle lag", 32'(irq_o), 0);
        tick();
        check("R6 irq raised", 32'(irq_o), 1);
        // R7 disable event
        wr(2'd0, 32'h0);
        check("R7 lag", 32'(irq_o), 1);
        tick();
        check("R7 irq dropped", 32'(irq_o), 0);
        check("R7 status kept", 32'(status_o), 32'h800);

        // R5 clear vs event
        wr(2'd0, 32'h800);
        dma_err_pulse = 1;
        wr(2'd2, 32'h800);
        dma_err_pulse = 0;
        check("R5 event wins", 32'(status_o), 32'h800);
        wr(2'd2, 32'h800);
        check("R5 cleared", 32'(status_o), 0);

        // R9 thresholds
        wr(2'd3, 32'hFFFF_FFFF);
        check("R9 all ones", {22'b0, tx_thr_o, rx_thr_o}, {22'b0, 5'd31, 5'd31});
        wr(2'd3, 32'h0000_0A03);
        check("R9 fields", {22'b0, tx_thr_o, rx_thr_o}, {22'b0, 5'd10, 5'd3});

        // R10 soft reset
        wr(2'd0, 32'hE00);
        dma_err_pulse = 1; tick(); dma_err_pulse = 0;
        soft_rst = 1; pkt_done_pulse = 1; tick();
        soft_rst = 0; pkt_done_pulse = 0;
        check("R10 status", 32'(status_o), 0);
        check("R10 enable", 32'(enable_o), 0);
        check("R10 sigen kept", 32'(sigen_o), 32'h800);
        check("R10 thr kept", {22'b0, tx_thr_o, rx_thr_o}, {22'b0, 5'd10, 5'd3});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule